// File: doc/BRIEF.md
# Multi-Channel Voltage Scan Threshold Checker

This block drives a single shared analog-to-digital converter through a fixed set of monitored voltage channels, one conversion at a time. It walks the channels in ascending index order and wraps around. Channels configured as off are passed over without a request, so the scan is shorter when fewer channels are in use. Each finished conversion is stored as a 10-bit result for its channel. The top 8 bits of that result are compared with the channel's own 8-bit over-limit and under-limit thresholds.

A channel can raise over or under flags only when its monitor enable is set, which means it belongs to a power sequencing slot or is held in plain monitor mode. A one-cycle fault-record strobe tells the surrounding fault logger to capture an event. A margining control stops threshold hits from being recorded while conversions go on. A falling edge on the active-low external fault input is always recorded.

A power-on reset clears everything, stored results included. A soft reboot command restarts the scan and clears the flags, but leaves the stored results untouched. The converter itself is outside this block and is seen only through its start/done/data handshake.

Top module: `volt_scan_checker`

## Requirements
- R1: Conversion requests go to the enabled channels in ascending index order, wrapping from the highest index to 0. A request is a one-cycle `conv_start` pulse with `conv_ch` naming the channel. The next request follows one cycle after the `conv_done` that completes the previous one.
- R2: A channel whose 2-bit field `ch_cfg[2*i+1:2*i]` equals 2'b11 is off. It is never requested, and it never sets a flag or causes a fault record.
- R3: On `conv_done`, `conv_data` is written into `results[10*i+9:10*i]` of the requested channel i. The new value is visible in the cycle after `conv_done`.
- R4: Let top8 be `conv_data[9:2]`. For an eligible channel, top8 > `ov_thr[8*i+7:8*i]` sets `ov_flag[i]`, and top8 < `uv_thr[8*i+7:8*i]` sets `uv_flag[i]`. A value equal to a threshold sets neither flag.
- R5: A conversion of a channel whose `ch_mon_en[i]` is 0 sets both of its flags to 0, whatever the data.
- R6: The result of a channel that is not being converted keeps its previous value. This includes a channel that has been switched off.
- R7: `rst` clears all results, flags and the strobe. `soft_reboot` clears the flags and the strobe and restarts the scan at the lowest enabled channel, but leaves every result unchanged.
- R8: While `margin_mode` is 1, a threshold hit does not pulse `fault_rec`, although results and flags still update. An external fault edge is still recorded.
- R9: With `margin_mode` 0, a conversion that sets either flag of its channel pulses `fault_rec` for exactly the one cycle in which the new result first appears.
- R10: A falling edge of `ext_fault_n` pulses `fault_rec` for one cycle, one clock later. Holding the input low records nothing further.
- R11: When every channel is off, no request is issued. When a channel is enabled again, scanning resumes at the first enabled channel after the last one converted.
- R12: A channel's flags change only when that channel's conversion completes, or when a reset or soft reboot occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_reboot | input | 1 | Restart scan and clear flags, keeping results |
| ch_cfg | input | 2*N_CH | Per-channel range/enable field, 2'b11 = off |
| ch_mon_en | input | N_CH | Channel assigned to a slot or in monitor mode |
| ov_thr | input | 8*N_CH | Per-channel over-limit threshold |
| uv_thr | input | 8*N_CH | Per-channel under-limit threshold |
| margin_mode | input | 1 | Suppress recording of threshold hits |
| ext_fault_n | input | 1 | Active-low external fault |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | CH_W | Channel being converted |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 10 | Conversion result |
| results | output | 10*N_CH | Stored result per channel |
| ov_flag | output | N_CH | Over-limit flag per channel |
| uv_flag | output | N_CH | Under-limit flag per channel |
| fault_rec | output | 1 | One-cycle fault-record strobe |

## Verification
The hardest situation to reach is a channel whose configuration changes while its conversion is already in flight. In that case the channel order was fixed under the old mask, but eligibility is judged under the new one. The bench reconfigures channels at the point where the next request has already been chosen. It tracks both masks in its model, so the rotation, the stale results and the flag gating are all checked through that window. The other hard point is the idle state with every channel off. The bench reaches it by switching all channels off while one conversion is pending, lets that conversion drain, and then checks the external fault path in the quiet scanner.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
    parameter int VS_NCH  = 6;
    parameter int VS_RESW = 10;
    parameter int VS_THRW = 8;
    localparam int VS_CFGW = 2;
    localparam logic [VS_CFGW-1:0] CFG_OFF = 2'b11;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_REQ  = 2'd1,
        SC_WAIT = 2'd2
    } scan_st_e;

    typedef struct packed {
        logic over;
        logic under;
    } lim_t;

    function automatic lim_t judge(input logic [VS_THRW-1:0] top,
                                   input logic [VS_THRW-1:0] hi,
                                   input logic [VS_THRW-1:0] lo,
                                   input logic               allow);
        lim_t r;
        r.over  = allow && (top > hi);
        r.under = allow && (top < lo);
        return r;
    endfunction
endpackage

// File: rtl/vscan_sequencer.sv
module vscan_sequencer
    import vscan_pkg::*;
#(
    parameter int N_CH = VS_NCH,
    parameter int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            soft_reboot,
    input  logic [N_CH-1:0] active,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            cap_en,
    output logic [CH_W-1:0] cap_ch
);
    scan_st_e        st;
    logic [CH_W-1:0] cur;
    logic            nxt_ok;
    logic [CH_W-1:0] nxt_ch;

    function automatic logic [CH_W:0] pick_after(input logic [N_CH-1:0] act,
                                                 input logic [CH_W-1:0] from);
        logic            found;
        logic [CH_W-1:0] sel;
        int              idx;
        found = 1'b0;
        sel   = '0;
        for (int k = 1; k <= N_CH; k++) begin
            idx = (int'(from) + k) % N_CH;
            if (!found && act[idx]) begin
                found = 1'b1;
                sel   = CH_W'(idx);
            end
        end
        return {found, sel};
    endfunction

    always_comb begin
        {nxt_ok, nxt_ch} = pick_after(active, cur);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_reboot) begin
            st  <= SC_IDLE;
            cur <= CH_W'(N_CH - 1);
        end else begin
            case (st)
                SC_IDLE: begin
                    if (nxt_ok) begin
                        cur <= nxt_ch;
                        st  <= SC_REQ;
                    end
                end
                SC_REQ: st <= SC_WAIT;
                SC_WAIT: begin
                    if (conv_done) begin
                        if (nxt_ok) begin
                            cur <= nxt_ch;
                            st  <= SC_REQ;
                        end else begin
                            st <= SC_IDLE;
                        end
                    end
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    assign conv_start = (st == SC_REQ);
    assign conv_ch    = cur;
    assign cap_en     = (st == SC_WAIT) && conv_done;
    assign cap_ch     = cur;
endmodule

// File: rtl/vscan_channel.sv
module vscan_channel
    import vscan_pkg::*;
#(
    parameter int RES_W = VS_RESW,
    parameter int THR_W = VS_THRW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_reboot,
    input  logic             cap,
    input  logic [RES_W-1:0] cap_data,
    input  logic             may_fault,
    input  logic [THR_W-1:0] hi_thr,
    input  logic [THR_W-1:0] lo_thr,
    output logic [RES_W-1:0] result,
    output logic             ov_flag,
    output logic             uv_flag,
    output logic             hit
);
    logic [THR_W-1:0] top;
    lim_t             lim;

    assign top = cap_data[RES_W-1 -: THR_W];
    assign lim = judge(top, hi_thr, lo_thr, may_fault);
    assign hit = cap && (lim.over || lim.under);

    // result storage survives a soft reboot
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (cap) begin
            result <= cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_reboot) begin
            ov_flag <= 1'b0;
            uv_flag <= 1'b0;
        end else if (cap) begin
            ov_flag <= lim.over;
            uv_flag <= lim.under;
        end
    end
endmodule

// File: rtl/vscan_fault_rec.sv
module vscan_fault_rec (
    input  logic clk,
    input  logic rst,
    input  logic soft_reboot,
    input  logic thr_hit,
    input  logic margin_mode,
    input  logic ext_fault_n,
    output logic fault_rec
);
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b1;
        end else begin
            ext_q <= ext_fault_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_reboot) begin
            fault_rec <= 1'b0;
        end else begin
            fault_rec <= (ext_q && !ext_fault_n) || (thr_hit && !margin_mode);
        end
    end
endmodule

// File: rtl/volt_scan_checker.sv
module volt_scan_checker
    import vscan_pkg::*;
#(
    parameter int N_CH  = VS_NCH,
    parameter int RES_W = VS_RESW,
    parameter int THR_W = VS_THRW,
    parameter int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_reboot,
    input  logic [VS_CFGW*N_CH-1:0] ch_cfg,
    input  logic [N_CH-1:0]        ch_mon_en,
    input  logic [THR_W*N_CH-1:0]  ov_thr,
    input  logic [THR_W*N_CH-1:0]  uv_thr,
    input  logic                   margin_mode,
    input  logic                   ext_fault_n,
    output logic                   conv_start,
    output logic [CH_W-1:0]        conv_ch,
    input  logic                   conv_done,
    input  logic [RES_W-1:0]       conv_data,
    output logic [RES_W*N_CH-1:0]  results,
    output logic [N_CH-1:0]        ov_flag,
    output logic [N_CH-1:0]        uv_flag,
    output logic                   fault_rec
);
    logic [N_CH-1:0] active;
    logic [N_CH-1:0] may_fault;
    logic [N_CH-1:0] hit;
    logic            cap_en;
    logic [CH_W-1:0] cap_ch;

    vscan_sequencer #(.N_CH(N_CH), .CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .soft_reboot(soft_reboot),
        .active     (active),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .cap_en     (cap_en),
        .cap_ch     (cap_ch)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign active[i]    = (ch_cfg[VS_CFGW*i +: VS_CFGW] != CFG_OFF);
        assign may_fault[i] = active[i] && ch_mon_en[i];

        vscan_channel #(.RES_W(RES_W), .THR_W(THR_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .soft_reboot(soft_reboot),
            .cap        (cap_en && (cap_ch == CH_W'(i))),
            .cap_data   (conv_data),
            .may_fault  (may_fault[i]),
            .hi_thr     (ov_thr[THR_W*i +: THR_W]),
            .lo_thr     (uv_thr[THR_W*i +: THR_W]),
            .result     (results[RES_W*i +: RES_W]),
            .ov_flag    (ov_flag[i]),
            .uv_flag    (uv_flag[i]),
            .hit        (hit[i])
        );
    end

    vscan_fault_rec u_frec (
        .clk        (clk),
        .rst        (rst),
        .soft_reboot(soft_reboot),
        .thr_hit    (|hit),
        .margin_mode(margin_mode),
        .ext_fault_n(ext_fault_n),
        .fault_rec  (fault_rec)
    );
endmodule

// File: rtl/vscan_checker.sv
module vscan_checker
    import vscan_pkg::*;
#(
    parameter int N_CH  = VS_NCH,
    parameter int RES_W = VS_RESW,
    parameter int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    soft_reboot,
    input logic [VS_CFGW*N_CH-1:0] ch_cfg,
    input logic                    margin_mode,
    input logic                    ext_fault_n,
    input logic                    conv_start,
    input logic [CH_W-1:0]         conv_ch,
    input logic                    conv_done,
    input logic [RES_W*N_CH-1:0]   results,
    input logic [N_CH-1:0]         ov_flag,
    input logic [N_CH-1:0]         uv_flag,
    input logic                    fault_rec
);
    logic all_off;
    always_comb begin
        all_off = 1'b1;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_cfg[VS_CFGW*i +: VS_CFGW] != CFG_OFF) all_off = 1'b0;
        end
    end

    // R1
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R1
    start_range_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (int'(conv_ch) < N_CH));

    // R6
    results_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(results));

    // R8
    margin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (margin_mode && ext_fault_n) |=> !fault_rec);

    // R12
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !soft_reboot) |=> ($stable(ov_flag) && $stable(uv_flag)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst || soft_reboot)
        (all_off && !conv_start) |=> !conv_start);
endmodule

bind volt_scan_checker vscan_checker #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_vscan_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_reboot(soft_reboot),
    .ch_cfg     (ch_cfg),
    .margin_mode(margin_mode),
    .ext_fault_n(ext_fault_n),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .conv_done  (conv_done),
    .results    (results),
    .ov_flag    (ov_flag),
    .uv_flag    (uv_flag),
    .fault_rec  (fault_rec)
);

// File: tb/test_volt_scan_checker.sv
module test_volt_scan_checker;
    localparam int NC = 6;
    localparam int RW = 10;
    localparam int TW = 8;
    localparam int CW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              soft_reboot = 1'b0;
    logic [2*NC-1:0]   ch_cfg = '0;
    logic [NC-1:0]     ch_mon_en = '1;
    logic [TW*NC-1:0]  ov_thr = '0;
    logic [TW*NC-1:0]  uv_thr = '0;
    logic              margin_mode = 1'b0;
    logic              ext_fault_n = 1'b1;
    logic              conv_start;
    logic [CW-1:0]     conv_ch;
    logic              conv_done = 1'b0;
    logic [RW-1:0]     conv_data = '0;
    logic [RW*NC-1:0]  results;
    logic [NC-1:0]     ov_flag;
    logic [NC-1:0]     uv_flag;
    logic              fault_rec;

    int checks = 0;
    int failures = 0;

    logic [RW-1:0] m_res [NC];
    logic [NC-1:0] m_ov;
    logic [NC-1:0] m_uv;
    int            last_ch;
    int            m_next;
    bit            m_idle;

    always #5 clk = ~clk;

    volt_scan_checker i_volt_scan_checker (
        .clk(clk), .rst(rst), .soft_reboot(soft_reboot), .ch_cfg(ch_cfg),
        .ch_mon_en(ch_mon_en), .ov_thr(ov_thr), .uv_thr(uv_thr),
        .margin_mode(margin_mode), .ext_fault_n(ext_fault_n),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data), .results(results), .ov_flag(ov_flag),
        .uv_flag(uv_flag), .fault_rec(fault_rec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_on(input int c);
        return ch_cfg[2*c +: 2] != 2'b11;
    endfunction

    function automatic int next_after(input int from);
        for (int k = 1; k <= NC; k++) begin
            int idx = (from + k) % NC;
            if (is_on(idx)) return idx;
        end
        return -1;
    endfunction

    task automatic check_state(input string req);
        for (int c = 0; c < NC; c++) begin
            chk(results[RW*c +: RW] == m_res[c], req, $sformatf("result ch%0d", c),
                int'(results[RW*c +: RW]), int'(m_res[c]));
        end
        chk(ov_flag == m_ov, req, "ov_flag", int'(ov_flag), int'(m_ov));
        chk(uv_flag == m_uv, req, "uv_flag", int'(uv_flag), int'(m_uv));
    endtask

    // one complete converter transaction, with model update and checks
    task automatic convert(input logic [RW-1:0] d, input int lat);
        int exp_ch;
        int wait_n;
        logic [TW-1:0] top;
        bit elig, ov, uv, exp_fr;
        exp_ch = m_idle ? next_after(last_ch) : m_next;
        wait_n = 0;
        while (!conv_start && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        chk(conv_start == 1'b1, "R1", "conv_start seen", int'(conv_start), 1);
        chk(int'(conv_ch) == exp_ch, "R1", "conv_ch order", int'(conv_ch), exp_ch);
        repeat (lat + 1) @(negedge clk);
        conv_done = 1'b1;
        conv_data = d;
        if (exp_ch >= 0) begin
            top  = d[RW-1 -: TW];
            elig = is_on(exp_ch) && ch_mon_en[exp_ch];
            ov   = elig && (top > ov_thr[TW*exp_ch +: TW]);
            uv   = elig && (top < uv_thr[TW*exp_ch +: TW]);
            m_res[exp_ch] = d;
            m_ov[exp_ch]  = ov;
            m_uv[exp_ch]  = uv;
            exp_fr  = (ov || uv) && !margin_mode;
            last_ch = exp_ch;
        end else begin
            exp_fr = 1'b0;
        end
        m_next = next_after(last_ch);
        m_idle = (m_next < 0);
        @(negedge clk);
        conv_done = 1'b0;
        check_state("R3 R4 R6");
        chk(fault_rec == exp_fr, "R9", "fault_rec after capture", int'(fault_rec), int'(exp_fr));
    endtask

    task automatic model_clear_all();
        for (int c = 0; c < NC; c++) m_res[c] = '0;
        m_ov = '0;
        m_uv = '0;
        last_ch = NC - 1;
        m_idle = 1'b1;
        m_next = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_clear_all();
        for (int c = 0; c < NC; c++) begin
            ov_thr[TW*c +: TW] = 8'd200;
            uv_thr[TW*c +: TW] = 8'd50;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check_state("R7");
        chk(fault_rec == 1'b0, "R7", "fault_rec after reset", int'(fault_rec), 0);

        // R4 threshold boundaries, channels 0..5 in order (R1)
        convert({8'd200, 2'b11}, 0);  // equal to upper: no flag
        convert({8'd201, 2'b00}, 1);  // above upper: over
        convert({8'd50,  2'b00}, 2);  // equal to lower: no flag
        convert({8'd49,  2'b11}, 0);  // below lower: under
        convert({8'd128, 2'b01}, 3);
        convert({8'd255, 2'b11}, 0);
        convert({8'd100, 2'b10}, 0);  // wraps back to channel 0

        // R2 skip channels 1 and 3; R6 their results stay
        ch_cfg[2*1 +: 2] = 2'b11;
        ch_cfg[2*3 +: 2] = 2'b11;
        for (int n = 0; n < 6; n++) convert(10'(n * 97 + 5), n % 3);
        chk(results[RW*1 +: RW] == m_res[1], "R2", "skipped ch1 result kept",
            int'(results[RW*1 +: RW]), int'(m_res[1]));

        // R5 channel without monitor enable never flags
        ch_mon_en = 6'b111110;
        ch_cfg = '0;
        for (int n = 0; n < 6; n++) convert(10'h3FF, 0);
        chk(ov_flag[0] == 1'b0, "R5", "ov_flag ch0 unmonitored", int'(ov_flag[0]), 0);
        ch_mon_en = '1;

        // R8 margining: flags update, no record
        margin_mode = 1'b1;
        for (int n = 0; n < 3; n++) convert(10'h004, 0);
        chk(uv_flag != '0, "R8", "flags still set in margin", int'(uv_flag), 1);
        margin_mode = 1'b0;

        // R11 all off: drain pending conversion, then idle
        ch_cfg = '1;
        convert(10'h200, 1);
        begin
            int starts = 0;
            for (int n = 0; n < 30; n++) begin
                @(negedge clk);
                if (conv_start) starts++;
            end
            chk(starts == 0, "R11", "no request while all off", starts, 0);
        end

        // R10 external fault edge, single pulse when held
        ext_fault_n = 1'b0;
        @(negedge clk);
        chk(fault_rec == 1'b1, "R10", "ext fall recorded", int'(fault_rec), 1);
        @(negedge clk);
        chk(fault_rec == 1'b0, "R10", "held low not re-recorded", int'(fault_rec), 0);
        ext_fault_n = 1'b1;
        margin_mode = 1'b1;
        @(negedge clk);
        ext_fault_n = 1'b0;
        @(negedge clk);
        chk(fault_rec == 1'b1, "R8", "ext fall recorded in margin", int'(fault_rec), 1);
        ext_fault_n = 1'b1;
        margin_mode = 1'b0;
        @(negedge clk);

        // R11 resume on the single re-enabled channel 4
        ch_cfg[2*4 +: 2] = 2'b00;
        for (int n = 0; n < 3; n++) convert(10'(300 + n), 0);
        chk(last_ch == 4, "R11", "resumed channel", last_ch, 4);

        // R7 soft reboot keeps results, clears flags, restarts at lowest channel
        ch_cfg = '0;
        convert(10'h3F0, 0);
        soft_reboot = 1'b1;
        @(negedge clk);
        soft_reboot = 1'b0;
        m_ov = '0;
        m_uv = '0;
        last_ch = NC - 1;
        m_idle = 1'b1;
        check_state("R7");
        convert(10'h155, 0);
        chk(last_ch == 0, "R7", "scan restarts at ch0", last_ch, 0);

        // random phase
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 6 == 0) begin
                for (int c = 0; c < NC; c++) begin
                    ch_cfg[2*c +: 2] = 2'($urandom % 4);
                    ov_thr[TW*c +: TW] = 8'($urandom);
                    uv_thr[TW*c +: TW] = 8'($urandom);
                end
                ch_mon_en = NC'($urandom);
                if (ch_cfg == '1) ch_cfg[2*($urandom % NC) +: 2] = 2'b00;
                margin_mode = ($urandom % 4 == 0);
            end
            convert(10'($urandom), int'($urandom % 4));
        end

        // R12 flags unchanged over idle cycles
        begin
            logic [NC-1:0] f0;
            f0 = ov_flag;
            repeat (1) @(negedge clk);
            chk(ov_flag == f0, "R12", "flags hold without capture", int'(ov_flag), int'(f0));
        end

        // R7 power-on reset clears results
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear_all();
        @(negedge clk);
        check_state("R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule